// File: doc/BRIEF.md
# Pulse-Coded Level Link with Watchdog

This block carries one logic level across a channel that passes only short pulses. The transmit half synchronises its input through a small flip-flop chain and detects edges. It turns each rising edge into a one-cycle pulse on a "set" line and each falling edge into a one-cycle pulse on a "clear" line. While the input stays constant, the transmit half re-sends the present level at a fixed interval. This keeps the far side correct at DC even if an earlier pulse was lost.

The receive half is a bistable that follows the pulses it is given. A watchdog counts bit-time strobes that pass with no pulse of either kind. When the count reaches its limit, the watchdog treats the sender as dead, forces the output to a fixed default level and raises a status flag. The next pulse of either kind releases the default. Both halves run on one clock. The channel between them stays outside the top module, so the transmit outputs and receive inputs are separate ports. The surrounding logic, or a bench, can wire them together, delay them or cut them.

Timing comes from a bit-time strobe input. Both the refresh interval and the watchdog limit are counted in those strobes, and the watchdog limit is always larger than the refresh interval. The link carries a level, not a data stream, so all pins are plain control and status signals with no handshake.

Top module: `pulse_level_link`

## Requirements
- R1: After `lvl_in` changes from 0 to 1 (held stable), `tx_set` goes high for exactly one cycle, visible after the third rising clock edge that samples the new value.
- R2: After `lvl_in` changes from 1 to 0 (held stable), `tx_clr` goes high for exactly one cycle, with the same latency as R1.
- R3: `tx_set` and `tx_clr` are never high together, and neither stays high for two consecutive cycles.
- R4: While the synchronised input stays constant, the transmitter sends a refresh pulse on the REFRESH_TICKS-th strobe after its previous pulse. The refresh is `tx_set` if the level is 1 and `tx_clr` if it is 0, and it repeats at that interval (default 12 strobes).
- R5: The refresh counter advances only on cycles where `bit_tick` is 1. With `bit_tick` held at 0, no refresh pulse appears.
- R6: A cycle with `rx_set`=1 and `rx_clr`=0 makes `rx_lvl` 1 after the next clock edge. `rx_clr`=1 makes it 0. With neither input high and no timeout, `rx_lvl` holds its value.
- R7: If `rx_set` and `rx_clr` are both 1 in the same cycle, `rx_lvl` becomes 0.
- R8: When WDOG_TICKS strobes (default 36) pass with no receive pulse, `rx_dead` becomes 1 and `rx_lvl` is forced to DEFAULT_LVL (default 0). This takes effect at the clock edge of the WDOG_TICKS-th strobe.
- R9: While `rx_dead` is 1, the first pulse on either receive input clears `rx_dead` at the next edge. It also sets `rx_lvl` according to R6/R7.
- R10: During and right after reset, `rx_lvl` equals DEFAULT_LVL, `rx_dead` is 1, and `tx_set`/`tx_clr` are 0.
- R11: With the transmit outputs wired to the receive inputs and `bit_tick` active, `rx_lvl` follows `lvl_in` with a latency of four clock edges, and `rx_dead` stays 0 while the input is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-time strobe that paces refresh and watchdog |
| lvl_in | input | 1 | Asynchronous level to carry across the link |
| tx_set | output | 1 | One-cycle pulse meaning "level is high" |
| tx_clr | output | 1 | One-cycle pulse meaning "level is low" |
| rx_set | input | 1 | Set pulse arriving from the channel |
| rx_clr | input | 1 | Clear pulse arriving from the channel; wins over rx_set |
| rx_lvl | output | 1 | Recovered level, or the default while the watchdog holds |
| rx_dead | output | 1 | High while the watchdog default is in force |

## Verification
Some properties are checked on every cycle. The transmit pulses never overlap and never last two cycles. The receiver obeys each set or clear pulse at the next edge, with clear winning a tie. Any pulse releases the watchdog. While the watchdog holds, the output sits at the default. Other behaviour is counted in strobes, and only directed scenarios can show it. These cover the exact three-edge latency from an input change to a pulse and the refresh landing on the twelfth strobe. They also cover the silence when strobes are gated, the timeout landing on the thirty-sixth strobe, and the end-to-end loop that stays alive through refreshes.

// File: rtl/plk_pkg.sv
package plk_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } pulse_t;

  localparam pulse_t PULSE_NONE = '{set: 1'b0, clr: 1'b0};

  function automatic pulse_t encode_level(input logic lvl);
    pulse_t p;
    p.set = lvl;
    p.clr = ~lvl;
    return p;
  endfunction

endpackage

// File: rtl/plk_sync.sv
module plk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/plk_tx.sv
module plk_tx
  import plk_pkg::*;
#(
  parameter int REFRESH_TICKS = 12,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic lvl_in,
  output logic set_o,
  output logic clr_o
);
  localparam int CW = $clog2(REFRESH_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(REFRESH_TICKS - 1);

  logic          lvl_s;
  logic          lvl_d;
  logic          edge_seen;
  logic [CW-1:0] idle_cnt;
  pulse_t        pulse_q;
  pulse_t        pulse_n;
  logic          refresh_due;

  plk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lvl_in),
    .q    (lvl_s)
  );

  assign edge_seen   = lvl_s ^ lvl_d;
  assign refresh_due = bit_tick && (idle_cnt == LAST);

  always_comb begin
    pulse_n = PULSE_NONE;
    if (edge_seen || refresh_due) pulse_n = encode_level(lvl_s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d    <= 1'b0;
      idle_cnt <= '0;
      pulse_q  <= PULSE_NONE;
    end else begin
      lvl_d   <= lvl_s;
      pulse_q <= pulse_n;
      if (edge_seen || refresh_due) idle_cnt <= '0;
      else if (bit_tick)            idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign set_o = pulse_q.set;
  assign clr_o = pulse_q.clr;
endmodule

// File: rtl/plk_rx.sv
module plk_rx
  import plk_pkg::*;
#(
  parameter int   WDOG_TICKS  = 36,
  parameter logic DEFAULT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic set_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic dead_o
);
  localparam int CW = $clog2(WDOG_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

  pulse_t        rx_p;
  logic          any_pulse;
  logic          expire;
  logic [CW-1:0] quiet_cnt;
  logic          lvl_q;
  logic          dead_q;

  assign rx_p      = '{set: set_i, clr: clr_i};
  assign any_pulse = rx_p.set | rx_p.clr;
  assign expire    = !dead_q && bit_tick && (quiet_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= DEFAULT_LVL;
      dead_q    <= 1'b1;
      quiet_cnt <= '0;
    end else if (any_pulse) begin
      lvl_q     <= !rx_p.clr;
      dead_q    <= 1'b0;
      quiet_cnt <= '0;
    end else if (expire) begin
      lvl_q     <= DEFAULT_LVL;
      dead_q    <= 1'b1;
      quiet_cnt <= '0;
    end else if (bit_tick && !dead_q) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign lvl_o  = lvl_q;
  assign dead_o = dead_q;
endmodule

// File: rtl/pulse_level_link.sv
module pulse_level_link #(
  parameter int   REFRESH_TICKS = 12,
  parameter int   WDOG_TICKS    = 36,
  parameter logic DEFAULT_LVL   = 1'b0,
  parameter int   SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic lvl_in,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic rx_lvl,
  output logic rx_dead
);
  generate
    if (WDOG_TICKS <= REFRESH_TICKS) begin : g_bad_cfg
      initial $error("watchdog limit must exceed refresh interval");
    end
  endgenerate

  plk_tx #(
    .REFRESH_TICKS(REFRESH_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .lvl_in  (lvl_in),
    .set_o   (tx_set),
    .clr_o   (tx_clr)
  );

  plk_rx #(
    .WDOG_TICKS (WDOG_TICKS),
    .DEFAULT_LVL(DEFAULT_LVL)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .set_i   (rx_set),
    .clr_i   (rx_clr),
    .lvl_o   (rx_lvl),
    .dead_o  (rx_dead)
  );
endmodule

// File: rtl/pulse_level_link_chk.sv
module pulse_level_link_chk #(
  parameter logic DEFAULT_LVL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic tx_set,
  input logic tx_clr,
  input logic rx_set,
  input logic rx_clr,
  input logic rx_lvl,
  input logic rx_dead
);
  // R3
  tx_no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set && tx_clr));

  // R3
  tx_set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> !tx_set);

  // R3
  tx_clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> !tx_clr);

  // R6
  rx_set_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && !rx_clr) |=> rx_lvl);

  // R7
  rx_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !rx_lvl);

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_set && !rx_clr && !rx_dead) |=> (rx_lvl == $past(rx_lvl)) || rx_dead);

  // R8
  rx_dead_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dead |-> (rx_lvl == DEFAULT_LVL));

  // R9
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set || rx_clr) |=> !rx_dead);
endmodule

bind pulse_level_link pulse_level_link_chk #(.DEFAULT_LVL(DEFAULT_LVL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tx_set (tx_set),
  .tx_clr (tx_clr),
  .rx_set (rx_set),
  .rx_clr (rx_clr),
  .rx_lvl (rx_lvl),
  .rx_dead(rx_dead)
);

// File: tb/pulse_level_link_tb_top.sv
`timescale 1ns/1ps
module pulse_level_link_tb_top;
  localparam int   REFRESH = 12;
  localparam int   WDOG    = 36;
  localparam logic DEF     = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic lvl_in = 1'b0;
  logic loop_en = 1'b0;
  logic drv_set = 1'b0;
  logic drv_clr = 1'b0;
  logic tx_set, tx_clr, rx_lvl, rx_dead;
  logic rx_set, rx_clr;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign rx_set = loop_en ? tx_set : drv_set;
  assign rx_clr = loop_en ? tx_clr : drv_clr;

  pulse_level_link #(
    .REFRESH_TICKS(REFRESH),
    .WDOG_TICKS   (WDOG),
    .DEFAULT_LVL  (DEF),
    .SYNC_STAGES  (2)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .lvl_in  (lvl_in),
    .tx_set  (tx_set),
    .tx_clr  (tx_clr),
    .rx_set  (rx_set),
    .rx_clr  (rx_clr),
    .rx_lvl  (rx_lvl),
    .rx_dead (rx_dead)
  );

  // vector fields: {set, clr, expected rx_lvl, expected rx_dead}
  localparam int NV = 8;
  localparam logic [3:0] VEC [NV] = '{
    4'b1010, 4'b0010, 4'b0100, 4'b0000,
    4'b1100, 4'b1010, 4'b1100, 4'b1010
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_edge();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int pulses;
    // R10 reset state
    repeat (3) tick_edge();
    chk("R10 rx_lvl", rx_lvl, DEF);
    chk("R10 rx_dead", rx_dead, 1);
    chk("R10 tx_set", tx_set, 0);
    chk("R10 tx_clr", tx_clr, 0);
    @(negedge clk); rst_n = 1'b1;
    tick_edge();
    chk("R10 rx_dead after release", rx_dead, 1);

    // R6 R7 receive table, strobes off
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drv_set = VEC[i][3];
      drv_clr = VEC[i][2];
      tick_edge();
      chk($sformatf("R6/R7 vec%0d lvl", i), rx_lvl, VEC[i][1]);
      chk($sformatf("R9 vec%0d dead", i), rx_dead, VEC[i][0]);
    end
    @(negedge clk); drv_set = 0; drv_clr = 0;

    // R1 rising edge latency
    @(negedge clk); bit_tick = 1'b1; lvl_in = 1'b1;
    tick_edge(); chk("R1 no early set", tx_set, 0);
    tick_edge(); chk("R1 no early set 2", tx_set, 0);
    tick_edge(); chk("R1 set pulse", tx_set, 1);
    chk("R3 no clr with set", tx_clr, 0);
    tick_edge(); chk("R3 set one cycle", tx_set, 0);
    // R4 refresh on 12th strobe after pulse
    pulses = 0;
    for (int k = 1; k < REFRESH - 1; k++) begin
      tick_edge(); pulses += tx_set + tx_clr;
    end
    chk("R4 quiet before refresh", pulses, 0);
    tick_edge(); chk("R4 refresh set", tx_set, 1);
    pulses = 0;
    for (int k = 1; k < REFRESH; k++) begin
      tick_edge(); pulses += tx_set + tx_clr;
    end
    chk("R4 quiet between refreshes", pulses, 0);
    tick_edge(); chk("R4 second refresh", tx_set, 1);

    // R5 strobes gated
    @(negedge clk); bit_tick = 1'b0;
    pulses = 0;
    for (int k = 0; k < 3 * REFRESH; k++) begin
      tick_edge(); pulses += tx_set + tx_clr;
    end
    chk("R5 no refresh without strobe", pulses, 0);

    // R2 falling edge
    @(negedge clk); lvl_in = 1'b0;
    tick_edge(); tick_edge();
    chk("R2 no early clr", tx_clr, 0);
    tick_edge(); chk("R2 clr pulse", tx_clr, 1);
    chk("R3 no set with clr", tx_set, 0);
    tick_edge(); chk("R2 clr one cycle", tx_clr, 0);

    // R8 watchdog
    @(negedge clk); bit_tick = 1'b1; drv_set = 1'b1;
    tick_edge();
    chk("R8 set before timeout", rx_lvl, 1);
    @(negedge clk); drv_set = 1'b0;
    for (int k = 1; k < WDOG; k++) tick_edge();
    chk("R8 not yet dead", rx_dead, 0);
    chk("R8 level held", rx_lvl, 1);
    tick_edge();
    chk("R8 dead", rx_dead, 1);
    chk("R8 default level", rx_lvl, DEF);
    repeat (5) tick_edge();
    chk("R8 stays dead", rx_dead, 1);

    // R9 release by a set pulse
    @(negedge clk); drv_set = 1'b1;
    tick_edge();
    chk("R9 released", rx_dead, 0);
    chk("R9 level", rx_lvl, 1);
    @(negedge clk); drv_set = 1'b0;

    // R11 end-to-end loop
    @(negedge clk); loop_en = 1'b1; lvl_in = 1'b0;
    repeat (4) tick_edge();
    @(negedge clk); lvl_in = 1'b1;
    repeat (3) tick_edge();
    chk("R11 no early rise", rx_lvl, 0);
    tick_edge();
    chk("R11 rise", rx_lvl, 1);
    repeat (3 * WDOG) tick_edge();
    chk("R11 alive", rx_dead, 0);
    chk("R11 level held", rx_lvl, 1);
    @(negedge clk); lvl_in = 1'b0;
    repeat (4) tick_edge();
    chk("R11 fall", rx_lvl, 0);

    finish_run();
  end
endmodule